// File: doc/BRIEF.md
# Byte-Lane Register Datapath with Width Control

This block is the register side of a small microcoded processor. It keeps four general registers (A, B, C, D) and a stack pointer, all two bytes wide. Around them sit two operand latches (X and Y) that feed an external ALU, a result latch (Z) that captures what the ALU returns, a memory address register, a memory data register and the program counter. Each cycle the sequencer drives a set of microinstruction fields. Some are strobes, which act on the rising clock edge. The others are level selects, which steer the multiplexers in front of those strobes.

The general-register write port has two features. First, its destination can come from the microinstruction, or from two instruction-register bits (bits 7 and 6) passed in from outside. Second, the write can cover both bytes, or only the low byte with the high byte left untouched. The memory data register also loads byte by byte, from either the result latch or the byte-wide data bus. One combinational operand bus shows the selected source. The sequencer uses it to feed X and Y, and it is also the only path by which register contents are visible.

Top module: `byte_lane_datapath`

## Requirements
- R1: After an asynchronous active-low reset, every register, the latches X, Y and Z, the address register, the data register and the program counter all read zero.
- R2: The operand bus follows `opnd_sel` in the same cycle: 000 gives zero, 001 A, 010 B, 011 C, 100 D, 101 the stack pointer, 110 the address register and 111 the data register.
- R3: With `wide_op`=1, `reg_ld` code 001, 010, 011, 100 or 101 writes the whole Z value into A, B, C, D or the stack pointer respectively, at the sampling edge.
- R4: `reg_ld` code 111 writes Z into the register chosen by `ir_dest` (instruction bits 7..6): 00 A, 01 B, 10 C, 11 D. It never targets the stack pointer.
- R5: `reg_ld` codes 000 and 110 write no register.
- R6: With `wide_op`=0, a register write replaces only bits 7..0 with Z[7:0] and keeps bits 15..8.
- R7: `mdr_lo_ld` loads bits 7..0 and `mdr_hi_ld` loads bits 15..8 of the data register. The new byte is `data_in` when `mdr_src`=1, and otherwise the matching byte of Z. A byte whose strobe is low is kept.
- R8: `mar_ld` loads the address register from the program counter when `mar_src`=1, and otherwise from Z. The address register holds when the strobe is low.
- R9: `pc_inc` adds one to the program counter, wrapping from FFFF to 0000. `pc_ld` loads it from Z. When both strobes are high, the load wins.
- R10: Each of X, Y and Z has its own strobe. X and Y capture the operand bus and Z captures `alu_result`. A latch whose strobe is low keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_dest | input | 2 | Instruction-register bits 7..6, used when `reg_ld` is 111 |
| reg_ld | input | 3 | Register write select (code table in R3 to R5) |
| wide_op | input | 1 | 1 = 16-bit write, 0 = low byte only |
| opnd_sel | input | 3 | Operand bus source (code table in R2) |
| x_ld | input | 1 | X latch strobe |
| y_ld | input | 1 | Y latch strobe |
| z_ld | input | 1 | Z latch strobe |
| alu_result | input | 16 | Value returned by the external ALU |
| mdr_src | input | 1 | Data register byte source: 1 = data bus, 0 = Z |
| mdr_lo_ld | input | 1 | Data register low-byte strobe |
| mdr_hi_ld | input | 1 | Data register high-byte strobe |
| data_in | input | 8 | Memory data bus byte |
| mar_src | input | 1 | Address register source: 1 = PC, 0 = Z |
| mar_ld | input | 1 | Address register strobe |
| pc_inc | input | 1 | Program counter increment strobe |
| pc_ld | input | 1 | Program counter load-from-Z strobe |
| src_bus | output | 16 | Operand bus |
| x_q | output | 16 | X latch |
| y_q | output | 16 | Y latch |
| z_q | output | 16 | Z latch |
| mar_q | output | 16 | Memory address register |
| mdr_q | output | 16 | Memory data register |
| pc_q | output | 16 | Program counter |

## Verification
Every strobe takes effect at the rising edge that samples it, so its result appears one edge later. The bench drives on the falling edge and samples on the next falling edge. The operand bus has no register, so it is checked a short delay after `opnd_sel` changes, within the same cycle. A register write consumes Z, which was itself loaded one edge earlier. Each table row therefore spends two edges: one to load Z, one to write the register. It then reads the register back through the operand bus without another edge.

// File: rtl/bld_pkg.sv
package bld_pkg;

   localparam int NUM_GPR    = 5;   // A, B, C, D, SP
   localparam int NUM_DIRECT = 4;   // registers reachable through the instruction field

   typedef enum logic [2:0] {
      WR_NONE  = 3'b000,
      WR_A     = 3'b001,
      WR_B     = 3'b010,
      WR_C     = 3'b011,
      WR_D     = 3'b100,
      WR_SP    = 3'b101,
      WR_RSVD  = 3'b110,
      WR_IRSEL = 3'b111
   } wr_code_e;

   typedef enum logic [2:0] {
      SRC_ZERO = 3'b000,
      SRC_A    = 3'b001,
      SRC_B    = 3'b010,
      SRC_C    = 3'b011,
      SRC_D    = 3'b100,
      SRC_SP   = 3'b101,
      SRC_MAR  = 3'b110,
      SRC_MDR  = 3'b111
   } src_code_e;

endpackage

// File: rtl/bld_lane_reg.sv
module bld_lane_reg #(
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   parameter logic [LANE_W*LANES-1:0] RST_VAL = '0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES-1:0]          lane_en,
   input  logic [LANE_W*LANES-1:0]   d,
   output logic [LANE_W*LANES-1:0]   q
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[l*LANE_W +: LANE_W] <= RST_VAL[l*LANE_W +: LANE_W];
         end else if (lane_en[l]) begin
            q[l*LANE_W +: LANE_W] <= d[l*LANE_W +: LANE_W];
         end
      end
   end

endmodule

// File: rtl/bld_wr_decode.sv
module bld_wr_decode
   import bld_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic [2:0]                      reg_ld,
   input  logic [1:0]                      ir_dest,
   input  logic                            wide_op,
   output logic [NUM_GPR-1:0][LANES-1:0]   wr_lane
);

   logic [LANES-1:0] lane_mask;

   // lane 0 is always written; upper lanes only for a full-width operation
   assign lane_mask[0] = 1'b1;
   for (genvar l = 1; l < LANES; l++) begin : g_mask
      assign lane_mask[l] = wide_op;
   end

   for (genvar r = 0; r < NUM_GPR; r++) begin : g_hit
      logic direct_hit;
      logic indirect_hit;
      assign direct_hit = (reg_ld == 3'(r + 1));
      if (r < NUM_DIRECT) begin : g_ind
         assign indirect_hit = (reg_ld == WR_IRSEL) && (ir_dest == 2'(r));
      end else begin : g_noind
         assign indirect_hit = 1'b0;
      end
      assign wr_lane[r] = (direct_hit || indirect_hit) ? lane_mask : '0;
   end

endmodule

// File: rtl/bld_operand_mux.sv
module bld_operand_mux
   import bld_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [2:0]                     opnd_sel,
   input  logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q,
   input  logic [DATA_W-1:0]              mar_q,
   input  logic [DATA_W-1:0]              mdr_q,
   output logic [DATA_W-1:0]              bus
);

   always_comb begin
      unique case (src_code_e'(opnd_sel))
         SRC_ZERO: bus = '0;
         SRC_A:    bus = gpr_q[0];
         SRC_B:    bus = gpr_q[1];
         SRC_C:    bus = gpr_q[2];
         SRC_D:    bus = gpr_q[3];
         SRC_SP:   bus = gpr_q[4];
         SRC_MAR:  bus = mar_q;
         SRC_MDR:  bus = mdr_q;
         default:  bus = '0;
      endcase
   end

endmodule

// File: rtl/bld_pc_unit.sv
module bld_pc_unit #(
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pc_ld,
   input  logic              pc_inc,
   input  logic [DATA_W-1:0] ld_val,
   output logic [DATA_W-1:0] pc_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= RST_VAL;
      end else if (pc_ld) begin
         pc_q <= ld_val;
      end else if (pc_inc) begin
         pc_q <= pc_q + DATA_W'(1);
      end
   end

endmodule

// File: rtl/byte_lane_datapath.sv
module byte_lane_datapath
   import bld_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   parameter logic [LANE_W*LANES-1:0] PC_RST = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               ir_dest,
   input  logic [2:0]               reg_ld,
   input  logic                     wide_op,
   input  logic [2:0]               opnd_sel,
   input  logic                     x_ld,
   input  logic                     y_ld,
   input  logic                     z_ld,
   input  logic [LANE_W*LANES-1:0]  alu_result,
   input  logic                     mdr_src,
   input  logic                     mdr_lo_ld,
   input  logic                     mdr_hi_ld,
   input  logic [LANE_W-1:0]        data_in,
   input  logic                     mar_src,
   input  logic                     mar_ld,
   input  logic                     pc_inc,
   input  logic                     pc_ld,
   output logic [LANE_W*LANES-1:0]  src_bus,
   output logic [LANE_W*LANES-1:0]  x_q,
   output logic [LANE_W*LANES-1:0]  y_q,
   output logic [LANE_W*LANES-1:0]  z_q,
   output logic [LANE_W*LANES-1:0]  mar_q,
   output logic [LANE_W*LANES-1:0]  mdr_q,
   output logic [LANE_W*LANES-1:0]  pc_q
);

   localparam int DATA_W = LANE_W * LANES;

   // elaboration-time parameter checks
   if (LANES != 2) begin : g_bad_lanes
      $error("byte_lane_datapath: LANES must be 2 (two data register strobes)");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("byte_lane_datapath: LANE_W must be positive");
   end

   // general register bank
   logic [NUM_GPR-1:0][LANES-1:0]  wr_lane;
   logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q;

   bld_wr_decode #(.LANES(LANES)) u_dec (
      .reg_ld  (reg_ld),
      .ir_dest (ir_dest),
      .wide_op (wide_op),
      .wr_lane (wr_lane)
   );

   for (genvar r = 0; r < NUM_GPR; r++) begin : g_gpr
      bld_lane_reg #(.LANE_W(LANE_W), .LANES(LANES), .RST_VAL('0)) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .lane_en (wr_lane[r]),
         .d       (z_q),
         .q       (gpr_q[r])
      );
   end

   // operand bus
   bld_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .opnd_sel (opnd_sel),
      .gpr_q    (gpr_q),
      .mar_q    (mar_q),
      .mdr_q    (mdr_q),
      .bus      (src_bus)
   );

   // operand and result latches
   bld_lane_reg #(.LANE_W(LANE_W), .LANES(LANES), .RST_VAL('0)) u_x (
      .clk (clk), .rst_n (rst_n), .lane_en ({LANES{x_ld}}), .d (src_bus), .q (x_q)
   );
   bld_lane_reg #(.LANE_W(LANE_W), .LANES(LANES), .RST_VAL('0)) u_y (
      .clk (clk), .rst_n (rst_n), .lane_en ({LANES{y_ld}}), .d (src_bus), .q (y_q)
   );
   bld_lane_reg #(.LANE_W(LANE_W), .LANES(LANES), .RST_VAL('0)) u_z (
      .clk (clk), .rst_n (rst_n), .lane_en ({LANES{z_ld}}), .d (alu_result), .q (z_q)
   );

   // memory data register: per-lane strobe, per-lane source
   logic [LANES-1:0]  mdr_en;
   logic [DATA_W-1:0] mdr_d;

   assign mdr_en = {mdr_hi_ld, mdr_lo_ld};
   for (genvar l = 0; l < LANES; l++) begin : g_mdr_src
      assign mdr_d[l*LANE_W +: LANE_W] = mdr_src ? data_in : z_q[l*LANE_W +: LANE_W];
   end

   bld_lane_reg #(.LANE_W(LANE_W), .LANES(LANES), .RST_VAL('0)) u_mdr (
      .clk (clk), .rst_n (rst_n), .lane_en (mdr_en), .d (mdr_d), .q (mdr_q)
   );

   // memory address register
   logic [DATA_W-1:0] mar_d;
   assign mar_d = mar_src ? pc_q : z_q;

   bld_lane_reg #(.LANE_W(LANE_W), .LANES(LANES), .RST_VAL('0)) u_mar (
      .clk (clk), .rst_n (rst_n), .lane_en ({LANES{mar_ld}}), .d (mar_d), .q (mar_q)
   );

   // program counter
   bld_pc_unit #(.DATA_W(DATA_W), .RST_VAL(PC_RST)) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .pc_ld  (pc_ld),
      .pc_inc (pc_inc),
      .ld_val (z_q),
      .pc_q   (pc_q)
   );

endmodule

// File: rtl/bld_chk.sv
module bld_chk #(
   parameter int LANE_W = 8,
   parameter int LANES  = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [2:0]              opnd_sel,
   input logic                    x_ld,
   input logic                    y_ld,
   input logic                    z_ld,
   input logic [LANE_W*LANES-1:0] alu_result,
   input logic                    mdr_src,
   input logic                    mdr_lo_ld,
   input logic                    mdr_hi_ld,
   input logic [LANE_W-1:0]       data_in,
   input logic                    mar_src,
   input logic                    mar_ld,
   input logic                    pc_inc,
   input logic                    pc_ld,
   input logic [LANE_W*LANES-1:0] src_bus,
   input logic [LANE_W*LANES-1:0] x_q,
   input logic [LANE_W*LANES-1:0] y_q,
   input logic [LANE_W*LANES-1:0] z_q,
   input logic [LANE_W*LANES-1:0] mar_q,
   input logic [LANE_W*LANES-1:0] mdr_q,
   input logic [LANE_W*LANES-1:0] pc_q
);

   localparam int DATA_W = LANE_W * LANES;

   AST_PC_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      pc_ld |=> pc_q == $past(z_q));                                        // R9
   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_inc && !pc_ld) |=> pc_q == $past(pc_q) + DATA_W'(1));             // R9
   AST_PC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_inc && !pc_ld) |=> $stable(pc_q));                               // R9
   AST_MAR_FROM_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (mar_ld && mar_src) |=> mar_q == $past(pc_q));                        // R8
   AST_MAR_FROM_Z: assert property (@(posedge clk) disable iff (!rst_n)
      (mar_ld && !mar_src) |=> mar_q == $past(z_q));                        // R8
   AST_MAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !mar_ld |=> $stable(mar_q));                                          // R8
   AST_MDR_LO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !mdr_lo_ld |=> $stable(mdr_q[LANE_W-1:0]));                           // R7
   AST_MDR_HI_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (mdr_hi_ld && mdr_src) |=> mdr_q[DATA_W-1:DATA_W-LANE_W] == $past(data_in)); // R7
   AST_Z_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      z_ld |=> z_q == $past(alu_result));                                   // R10
   AST_X_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      x_ld |=> x_q == $past(src_bus));                                      // R10
   AST_Y_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !y_ld |=> $stable(y_q));                                              // R10
   AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      opnd_sel == 3'b000 |-> src_bus == '0);                                // R2

endmodule

bind byte_lane_datapath bld_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .opnd_sel   (opnd_sel),
   .x_ld       (x_ld),
   .y_ld       (y_ld),
   .z_ld       (z_ld),
   .alu_result (alu_result),
   .mdr_src    (mdr_src),
   .mdr_lo_ld  (mdr_lo_ld),
   .mdr_hi_ld  (mdr_hi_ld),
   .data_in    (data_in),
   .mar_src    (mar_src),
   .mar_ld     (mar_ld),
   .pc_inc     (pc_inc),
   .pc_ld      (pc_ld),
   .src_bus    (src_bus),
   .x_q        (x_q),
   .y_q        (y_q),
   .z_q        (z_q),
   .mar_q      (mar_q),
   .mdr_q      (mdr_q),
   .pc_q       (pc_q)
);

// File: tb/tb_byte_lane_datapath.sv
`timescale 1ns/1ps
module tb_byte_lane_datapath;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ir_dest = '0;
   logic [2:0]  reg_ld = '0;
   logic        wide_op = 1'b0;
   logic [2:0]  opnd_sel = '0;
   logic        x_ld = 1'b0, y_ld = 1'b0, z_ld = 1'b0;
   logic [15:0] alu_result = '0;
   logic        mdr_src = 1'b0, mdr_lo_ld = 1'b0, mdr_hi_ld = 1'b0;
   logic [7:0]  data_in = '0;
   logic        mar_src = 1'b0, mar_ld = 1'b0;
   logic        pc_inc = 1'b0, pc_ld = 1'b0;
   logic [15:0] src_bus, x_q, y_q, z_q, mar_q, mdr_q, pc_q;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   byte_lane_datapath dut (
      .clk(clk), .rst_n(rst_n), .ir_dest(ir_dest), .reg_ld(reg_ld), .wide_op(wide_op),
      .opnd_sel(opnd_sel), .x_ld(x_ld), .y_ld(y_ld), .z_ld(z_ld), .alu_result(alu_result),
      .mdr_src(mdr_src), .mdr_lo_ld(mdr_lo_ld), .mdr_hi_ld(mdr_hi_ld), .data_in(data_in),
      .mar_src(mar_src), .mar_ld(mar_ld), .pc_inc(pc_inc), .pc_ld(pc_ld),
      .src_bus(src_bus), .x_q(x_q), .y_q(y_q), .z_q(z_q), .mar_q(mar_q),
      .mdr_q(mdr_q), .pc_q(pc_q)
   );

   // row: {reg_ld[2:0], ir_dest[1:0], wide, z[15:0], read_sel[2:0], expect[15:0], req[3:0]}
   localparam logic [44:0] VEC [12] = '{
      {3'b001, 2'b00, 1'b1, 16'h1234, 3'b001, 16'h1234, 4'd3},  // R3 A
      {3'b010, 2'b00, 1'b1, 16'hABCD, 3'b010, 16'hABCD, 4'd3},  // R3 B
      {3'b011, 2'b00, 1'b1, 16'h5A5A, 3'b011, 16'h5A5A, 4'd3},  // R3 C
      {3'b100, 2'b00, 1'b1, 16'h0F0F, 3'b100, 16'h0F0F, 4'd3},  // R3 D
      {3'b101, 2'b00, 1'b1, 16'hBEEF, 3'b101, 16'hBEEF, 4'd3},  // R3 SP
      {3'b001, 2'b00, 1'b0, 16'hFF77, 3'b001, 16'h1277, 4'd6},  // R6 low byte only
      {3'b111, 2'b11, 1'b1, 16'hCAFE, 3'b100, 16'hCAFE, 4'd4},  // R4 ir 11 -> D
      {3'b111, 2'b01, 1'b0, 16'h9988, 3'b010, 16'hAB88, 4'd4},  // R4 + R6 ir 01 -> B
      {3'b110, 2'b00, 1'b1, 16'hDEAD, 3'b001, 16'h1277, 4'd5},  // R5 reserved code
      {3'b000, 2'b00, 1'b1, 16'hFFFF, 3'b101, 16'hBEEF, 4'd5},  // R5 no write
      {3'b111, 2'b00, 1'b1, 16'h0101, 3'b001, 16'h0101, 4'd4},  // R4 ir 00 -> A
      {3'b111, 2'b10, 1'b1, 16'h7777, 3'b011, 16'h7777, 4'd4}   // R4 ir 10 -> C
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic look(input logic [2:0] sel, output logic [15:0] v);
      opnd_sel = sel;
      #1;
      v = src_bus;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) tick();
      // R1: reset state
      chk("R1 pc", pc_q, 16'h0000);
      chk("R1 x", x_q, 16'h0000);
      chk("R1 z", z_q, 16'h0000);
      chk("R1 mar", mar_q, 16'h0000);
      chk("R1 mdr", mdr_q, 16'h0000);
      rst_n = 1'b1;
      tick();
      for (int s = 1; s <= 5; s++) begin
         look(3'(s), v);
         chk($sformatf("R1 reg sel %0d", s), v, 16'h0000);
      end

      // table walk: load Z, write register, read through operand bus
      for (int i = 0; i < 12; i++) begin
         alu_result = VEC[i][38:23];
         z_ld = 1'b1;
         tick();
         z_ld = 1'b0;
         reg_ld = VEC[i][44:42];
         ir_dest = VEC[i][41:40];
         wide_op = VEC[i][39];
         tick();
         reg_ld = 3'b000;
         look(VEC[i][22:20], v);
         chk($sformatf("R%0d table row %0d", VEC[i][3:0], i), v, VEC[i][19:4]);
      end

      // R10: independent latch strobes
      opnd_sel = 3'b001; x_ld = 1'b1;
      tick();
      x_ld = 1'b0;
      chk("R10 x capture", x_q, 16'h0101);
      chk("R10 y untouched", y_q, 16'h0000);
      opnd_sel = 3'b010; y_ld = 1'b1;
      tick();
      y_ld = 1'b0;
      chk("R10 y capture", y_q, 16'hAB88);
      chk("R10 x kept", x_q, 16'h0101);
      alu_result = 16'h1111;
      tick();
      chk("R10 z kept", z_q, 16'h7777);

      // R7: data register byte loads
      alu_result = 16'h3344; z_ld = 1'b1;
      tick();
      z_ld = 1'b0;
      mdr_src = 1'b0; mdr_lo_ld = 1'b1;
      tick();
      mdr_lo_ld = 1'b0;
      chk("R7 low from Z", mdr_q, 16'h0044);
      mdr_src = 1'b1; data_in = 8'hA5; mdr_hi_ld = 1'b1;
      tick();
      mdr_hi_ld = 1'b0;
      chk("R7 high from bus", mdr_q, 16'hA544);
      data_in = 8'h11; mdr_lo_ld = 1'b1;
      tick();
      mdr_lo_ld = 1'b0;
      chk("R7 low from bus", mdr_q, 16'hA511);
      mdr_src = 1'b0; mdr_lo_ld = 1'b1; mdr_hi_ld = 1'b1;
      tick();
      mdr_lo_ld = 1'b0; mdr_hi_ld = 1'b0;
      chk("R7 both from Z", mdr_q, 16'h3344);
      look(3'b111, v);
      chk("R2 sel mdr", v, 16'h3344);
      look(3'b000, v);
      chk("R2 sel zero", v, 16'h0000);

      // R8 / R9: address register and program counter
      pc_inc = 1'b1;
      tick();
      chk("R9 inc once", pc_q, 16'h0001);
      tick();
      pc_inc = 1'b0;
      chk("R9 inc twice", pc_q, 16'h0002);
      mar_src = 1'b1; mar_ld = 1'b1;
      tick();
      chk("R8 mar from pc", mar_q, 16'h0002);
      mar_src = 1'b0;
      tick();
      mar_ld = 1'b0;
      chk("R8 mar from z", mar_q, 16'h3344);
      look(3'b110, v);
      chk("R2 sel mar", v, 16'h3344);
      pc_ld = 1'b1;
      tick();
      chk("R9 load from z", pc_q, 16'h3344);
      pc_inc = 1'b1;
      tick();
      pc_inc = 1'b0; pc_ld = 1'b0;
      chk("R9 load beats inc", pc_q, 16'h3344);
      alu_result = 16'hFFFF; z_ld = 1'b1;
      tick();
      z_ld = 1'b0; pc_ld = 1'b1;
      tick();
      pc_ld = 1'b0; pc_inc = 1'b1;
      tick();
      pc_inc = 1'b0;
      chk("R9 wrap", pc_q, 16'h0000);
      tick();
      chk("R8 mar holds", mar_q, 16'h3344);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule